// File: doc/BRIEF.md
# Wait-for-interrupt power sequencer

This block sits between a processor pipeline and its external bus port and manages the low-power state entered through a wait-for-interrupt instruction. The pipeline pulses a request together with a two-bit power-mode code. From the following cycle the block stops granting new external transactions. It then waits until the count of outstanding transactions has drained to zero. Only then does it halt the pipeline and raise one of three mode outputs (sleep, hibernate or suspend), which tells external hardware that it may safely gate clocks or reset logic.

Two wake inputs, either of which ends the low-power state, return the block to running. A one-cycle resume pulse then tells the pipeline to continue with the instruction after the wait. The pulse looks the same whatever caused the wake, so software that finds nothing to do can simply wait again. A debugger wake request is registered and forwarded to an output. External logic can then restart clocks and drive one of the wake inputs; the request does not end the low-power state by itself.

Top module: `wfi_power_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to the running state. After that edge every output is 0 and `outstanding` is 0.
- R2: `outstanding` goes up by one for each cycle with `issue_grant` high. It goes down by one for each cycle with `txn_done` high while it is non-zero. `txn_done` at zero is ignored. A grant and a completion in the same cycle leave it unchanged.
- R3: `issue_grant` is high exactly when `issue_req` is high, `bus_stall` is low and `outstanding` is below its maximum of 2^CNT_W-1.
- R4: From the cycle after `wfi_req` is accepted while running, `bus_stall` stays high until the block is running again, and no transaction is granted in that time.
- R5: `pipe_halt` rises only on the edge after a cycle in which `outstanding` was 0 during the drain. It is never high while `outstanding` is non-zero.
- R6: While halted, exactly one mode output is high, chosen by the code latched with the request: 00 sleep, 01 hibernate, 10 suspend, 11 sleep. While not halted, all three are low.
- R7: While halted, a high level on `wake_a` or `wake_b` at a clock edge clears `pipe_halt`, `bus_stall` and the mode output on that same edge.
- R8: If a wake input is high in the drain cycle that finds `outstanding` at 0, the block goes straight back to running, without raising `pipe_halt` or any mode output.
- R9: `resume_pulse` is high for exactly the one cycle after each return to running, whether the return came from halt or straight from the drain.
- R10: `dbg_wakeup` equals `dbg_wake_req` delayed by one clock. `dbg_wake_req` on its own never ends the halt.
- R11: `wfi_req` is ignored while the block is draining or halted, and the latched mode does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Wait-for-interrupt executed (one-cycle request) |
| wfi_mode | input | 2 | Requested power mode code, sampled with `wfi_req` |
| issue_req | input | 1 | Pipeline wants to start an external transaction |
| txn_done | input | 1 | One outstanding external transaction has completed |
| wake_a | input | 1 | Wake input, level sensitive |
| wake_b | input | 1 | Second wake input, level sensitive |
| dbg_wake_req | input | 1 | Debugger asks for a wake |
| issue_grant | output | 1 | Transaction may start this cycle |
| outstanding | output | CNT_W | Outstanding transaction count |
| bus_stall | output | 1 | Drain or halt in progress; no new transactions |
| pipe_halt | output | 1 | Pipeline halted |
| resume_pulse | output | 1 | Continue at the next instruction |
| sleep_o | output | 1 | Halted in sleep mode |
| hibernate_o | output | 1 | Halted in hibernate mode |
| suspend_o | output | 1 | Halted in suspend mode |
| dbg_wakeup | output | 1 | Registered debugger wake request for external logic |

## Verification
The bench targets five cases. The first is a wait request that arrives with transactions still in flight: a design that halts early would raise `pipe_halt` with a non-zero count. The second is a wake level already present when the drain empties: a wrong design would flash a mode output or the halt for one cycle. The third is code 11 and the saturated counter: a wrong decode would raise no output or the wrong one, and a missing limit would make the count wrap to zero. The fourth is a grant and a completion in the same cycle, and a completion at zero: a wrong count here shows up at once in `outstanding`. The fifth is debugger requests that arrive while halted with no wake input: a design that wakes on them would drop `pipe_halt` when it should stay high.

// File: rtl/wfi_seq_pkg.sv
package wfi_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } seq_state_t;

  localparam int NUM_MODES = 3;

  typedef enum logic [1:0] {
    PM_SLEEP     = 2'd0,
    PM_HIBERNATE = 2'd1,
    PM_SUSPEND   = 2'd2
  } pm_sel_t;

  // code 11 is not a distinct mode; it falls back to sleep
  function automatic pm_sel_t decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    decode_mode = PM_HIBERNATE;
      2'd2:    decode_mode = PM_SUSPEND;
      default: decode_mode = PM_SLEEP;
    endcase
  endfunction

endpackage

// File: rtl/wfi_txn_tracker.sv
module wfi_txn_tracker #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_req,
  input  logic             txn_done,
  input  logic             stall,
  output logic             issue_grant,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic retire;

  assign issue_grant = issue_req & ~stall & (count != CNT_MAX);
  assign retire      = txn_done & (count != CNT_ZERO);
  assign empty       = (count == CNT_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= CNT_ZERO;
    end else if (issue_grant && !retire) begin
      count <= count + 1'b1;
    end else if (!issue_grant && retire) begin
      count <= count - 1'b1;
    end
  end

  // while stalled the count may only fall
  assert_stall_no_growth_R4: assert property (@(posedge clk) disable iff (rst)
    stall |=> (count <= $past(count)));

  // a completion at zero leaves the count at zero when nothing is granted
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_ZERO && !issue_grant) |=> (count == CNT_ZERO));

endmodule

// File: rtl/wfi_mode_onehot.sv
module wfi_mode_onehot
  import wfi_seq_pkg::*;
#(
  parameter int N = NUM_MODES
) (
  input  pm_sel_t        sel,
  output logic [N-1:0]   onehot
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign onehot[g] = (int'(sel) == g);
  end
endmodule

// File: rtl/wfi_seq_fsm.sv
module wfi_seq_fsm
  import wfi_seq_pkg::*;
#(
  parameter int N = NUM_MODES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wfi_req,
  input  logic [1:0]   mode_code,
  input  logic         drained,
  input  logic         wake_any,
  output logic         bus_stall,
  output logic         pipe_halt,
  output logic         resume,
  output logic [N-1:0] mode_out
);
  seq_state_t state, nxt;
  pm_sel_t    sel_q;
  logic [N-1:0] sel_onehot;
  logic       leave_low;

  wfi_mode_onehot #(.N(N)) u_dec (
    .sel    (sel_q),
    .onehot (sel_onehot)
  );

  always_comb begin
    nxt       = state;
    leave_low = 1'b0;
    case (state)
      ST_RUN:   if (wfi_req) nxt = ST_DRAIN;
      ST_DRAIN: if (drained) begin
                  if (wake_any) begin
                    nxt       = ST_RUN;
                    leave_low = 1'b1;
                  end else begin
                    nxt = ST_HALT;
                  end
                end
      ST_HALT:  if (wake_any) begin
                  nxt       = ST_RUN;
                  leave_low = 1'b1;
                end
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      sel_q     <= PM_SLEEP;
      bus_stall <= 1'b0;
      pipe_halt <= 1'b0;
      resume    <= 1'b0;
      mode_out  <= '0;
    end else begin
      state     <= nxt;
      if (state == ST_RUN && wfi_req) sel_q <= decode_mode(mode_code);
      bus_stall <= (nxt != ST_RUN);
      pipe_halt <= (nxt == ST_HALT);
      resume    <= leave_low;
      mode_out  <= (nxt == ST_HALT) ? sel_onehot : '0;
    end
  end

  assert_mode_onehot0_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mode_out));

  assert_mode_when_halted_R6: assert property (@(posedge clk) disable iff (rst)
    pipe_halt |-> ($countones(mode_out) == 1));

  assert_wake_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (pipe_halt && wake_any) |=> (!pipe_halt && !bus_stall && mode_out == '0));

  assert_direct_return_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN && drained && wake_any) |=> (!pipe_halt && mode_out == '0 && resume));

  assert_resume_single_R9: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume);

  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN) |=> $stable(sel_q));

endmodule

// File: rtl/wfi_power_seq.sv
module wfi_power_seq
  import wfi_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wfi_req,
  input  logic [1:0]       wfi_mode,
  input  logic             issue_req,
  input  logic             txn_done,
  input  logic             wake_a,
  input  logic             wake_b,
  input  logic             dbg_wake_req,
  output logic             issue_grant,
  output logic [CNT_W-1:0] outstanding,
  output logic             bus_stall,
  output logic             pipe_halt,
  output logic             resume_pulse,
  output logic             sleep_o,
  output logic             hibernate_o,
  output logic             suspend_o,
  output logic             dbg_wakeup
);
  logic                 drained;
  logic [NUM_MODES-1:0] mode_vec;

  wfi_txn_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk         (clk),
    .rst         (rst),
    .issue_req   (issue_req),
    .txn_done    (txn_done),
    .stall       (bus_stall),
    .issue_grant (issue_grant),
    .count       (outstanding),
    .empty       (drained)
  );

  wfi_seq_fsm #(.N(NUM_MODES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wfi_req   (wfi_req),
    .mode_code (wfi_mode),
    .drained   (drained),
    .wake_any  (wake_a | wake_b),
    .bus_stall (bus_stall),
    .pipe_halt (pipe_halt),
    .resume    (resume_pulse),
    .mode_out  (mode_vec)
  );

  assign sleep_o     = mode_vec[PM_SLEEP];
  assign hibernate_o = mode_vec[PM_HIBERNATE];
  assign suspend_o   = mode_vec[PM_SUSPEND];

  always_ff @(posedge clk) begin
    if (rst) dbg_wakeup <= 1'b0;
    else     dbg_wakeup <= dbg_wake_req;
  end

  assert_halt_drained_R5: assert property (@(posedge clk) disable iff (rst)
    pipe_halt |-> (outstanding == '0));

  assert_dbg_forward_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dbg_wakeup == $past(dbg_wake_req)));

  assert_dbg_no_wake_R10: assert property (@(posedge clk) disable iff (rst)
    (pipe_halt && !wake_a && !wake_b) |=> pipe_halt);

endmodule

// File: tb/wfi_power_seq_tb.sv
module wfi_power_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int CMAX       = (1 << CNT_W) - 1;
  localparam int PHASE_LEN  = 250;
  localparam int NPHASE     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfi_req = 0, issue_req = 0, txn_done = 0, wake_a = 0, wake_b = 0, dbg_wake_req = 0;
  logic [1:0] wfi_mode = 0;
  logic issue_grant, bus_stall, pipe_halt, resume_pulse, sleep_o, hibernate_o, suspend_o, dbg_wakeup;
  logic [CNT_W-1:0] outstanding;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state: 0 running, 1 draining, 2 halted
  int m_st = 0, m_cnt = 0, m_mode = 0, m_res = 0, m_dbg = 0;
  int seen_halt[3] = '{0, 0, 0};
  int seen_direct = 0, seen_sat = 0, seen_code3 = 0, seen_dbg_hold = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wfi_power_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfi_mode(wfi_mode),
    .issue_req(issue_req), .txn_done(txn_done), .wake_a(wake_a), .wake_b(wake_b),
    .dbg_wake_req(dbg_wake_req), .issue_grant(issue_grant), .outstanding(outstanding),
    .bus_stall(bus_stall), .pipe_halt(pipe_halt), .resume_pulse(resume_pulse),
    .sleep_o(sleep_o), .hibernate_o(hibernate_o), .suspend_o(suspend_o),
    .dbg_wakeup(dbg_wakeup)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_grant();
    return (issue_req && m_st == 0 && m_cnt != CMAX) ? 1 : 0;
  endfunction

  task automatic compare_all();
    chk("R3", "issue_grant", int'(issue_grant), exp_grant());
    chk("R2", "outstanding", int'(outstanding), m_cnt);
    chk("R4", "bus_stall", int'(bus_stall), (m_st != 0) ? 1 : 0);
    chk("R5", "pipe_halt", int'(pipe_halt), (m_st == 2) ? 1 : 0);
    chk("R9", "resume_pulse", int'(resume_pulse), m_res);
    chk("R6", "sleep_o", int'(sleep_o), (m_st == 2 && m_mode == 0) ? 1 : 0);
    chk("R6", "hibernate_o", int'(hibernate_o), (m_st == 2 && m_mode == 1) ? 1 : 0);
    chk("R6", "suspend_o", int'(suspend_o), (m_st == 2 && m_mode == 2) ? 1 : 0);
    chk("R10", "dbg_wakeup", int'(dbg_wakeup), m_dbg);
  endtask

  task automatic model_step();
    int gr, rt, wk;
    gr = exp_grant();
    rt = (txn_done && m_cnt != 0) ? 1 : 0;
    wk = (wake_a || wake_b) ? 1 : 0;
    m_res = 0;
    if (m_cnt == CMAX && issue_req && m_st == 0) seen_sat++;
    case (m_st)
      0: if (wfi_req) begin
           m_st = 1;
           m_mode = (wfi_mode == 2'd3) ? 0 : int'(wfi_mode);
           if (wfi_mode == 2'd3) seen_code3++;
         end
      1: if (m_cnt == 0) begin
           if (wk) begin m_st = 0; m_res = 1; seen_direct++; end   // R8
           else begin m_st = 2; seen_halt[m_mode]++; end
         end
      2: if (wk) begin m_st = 0; m_res = 1; end                    // R7
         else if (dbg_wake_req) seen_dbg_hold++;                  // R10
      default: m_st = 0;
    endcase
    m_cnt = m_cnt + gr - rt;
    m_dbg = dbg_wake_req ? 1 : 0;
  endtask

  function automatic logic roll(input int pct);
    return ($urandom_range(99) < pct);
  endfunction

  initial begin
    int p_iss, p_done, p_wfi, p_wake, p_dbg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "pipe_halt", int'(pipe_halt), 0);
    chk("R1", "bus_stall", int'(bus_stall), 0);
    chk("R1", "outstanding", int'(outstanding), 0);
    chk("R1", "modes", int'({sleep_o, hibernate_o, suspend_o, resume_pulse, dbg_wakeup}), 0);
    rst = 1'b0;
    for (int cyc = 0; cyc < PHASE_LEN * NPHASE; cyc++) begin
      case ((cyc / PHASE_LEN) % NPHASE)
        0: begin p_iss = 60; p_done = 40; p_wfi = 5;  p_wake = 10; p_dbg = 5;  end
        1: begin p_iss = 95; p_done = 5;  p_wfi = 0;  p_wake = 0;  p_dbg = 0;  end // saturation
        2: begin p_iss = 30; p_done = 30; p_wfi = 20; p_wake = 3;  p_dbg = 5;  end // long halts
        3: begin p_iss = 10; p_done = 70; p_wfi = 30; p_wake = 70; p_dbg = 0;  end // wake at drain end
        4: begin p_iss = 40; p_done = 40; p_wfi = 15; p_wake = 3;  p_dbg = 60; end // debug while halted
        5: begin p_iss = 50; p_done = 50; p_wfi = 40; p_wake = 20; p_dbg = 10; end // wfi while busy
        6: begin p_iss = 0;  p_done = 90; p_wfi = 10; p_wake = 5;  p_dbg = 0;  end // completions at zero
        default: begin p_iss = 70; p_done = 60; p_wfi = 10; p_wake = 8; p_dbg = 20; end
      endcase
      @(negedge clk);
      issue_req    = roll(p_iss);
      txn_done     = roll(p_done);
      wfi_req      = roll(p_wfi);
      wfi_mode     = 2'($urandom_range(3));
      wake_a       = roll(p_wake / 2 + 1) ? 1'b1 : 1'b0;
      wake_b       = roll(p_wake / 2) ? 1'b1 : 1'b0;
      dbg_wake_req = roll(p_dbg);
      #1;
      compare_all();
      @(posedge clk);
      model_step();
    end
    // coverage of corner cases the requirements name
    chk("R6", "halts in sleep seen", int'(seen_halt[0] > 0), 1);
    chk("R6", "halts in hibernate seen", int'(seen_halt[1] > 0), 1);
    chk("R6", "halts in suspend seen", int'(seen_halt[2] > 0), 1);
    chk("R6", "code 11 requested", int'(seen_code3 > 0), 1);
    chk("R8", "direct return seen", int'(seen_direct > 0), 1);
    chk("R3", "saturation seen", int'(seen_sat > 0), 1);
    chk("R10", "debug request while halted seen", int'(seen_dbg_hold > 0), 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule